// File: doc/BRIEF.md
# Gated Event Counter Read Unit

This unit keeps two independent event counters, each 40 bits wide, and answers read requests that a processor pipeline issues on behalf of running code. Each counter has an enable bit and a source selector that chooses one of several event strobes. While a counter is enabled and its chosen strobe is high, it advances by one per clock.

A read request carries the requester's privilege level, a 32-bit selector value and a control-register word. Privileged code (level zero) may always read. Code at any other level may read only when the user-access enable bit of the control word is set. The selector must be exactly 0 or 1. If either check fails, the unit reports a general-protection fault with error code zero. Otherwise it returns the selected count, zero-extended to 64 bits, as a high word and a low word. The response is a single-cycle pulse one clock after the request. A read does not change either counter, and the unit has no flag outputs.

Top module: `evt_counter_reader`

## Requirements
- R1: Counter n advances by exactly one on every clock where its bit n of `cnt_en_i` is high and its selected event source is high. In every other cycle it keeps its value. The two counters advance independently.
- R2: Counter n takes its event from `evt_src_i[k]`, where k is the value of bits [2n+1:2n] of `cnt_src_sel_i`.
- R3: A counter holding all ones wraps to zero on its next advance.
- R4: A synchronous reset clears both counters, `rd_valid_o`, `rd_fault_o`, `rd_hi_o`, `rd_lo_o` and `rd_err_code_o`.
- R5: The response appears on the clock after `rd_req_i` was sampled high and lasts exactly one cycle. The value returned is the count as it stood before any advance in the request cycle.
- R6: With `rd_sel_i` = 0 the unit returns counter 0, and with `rd_sel_i` = 1 it returns counter 1. The count is zero-extended into a 64-bit result: `rd_lo_o` carries count bits 31:0, `rd_hi_o` carries the remaining upper count bits, and every result bit above the counter width is zero.
- R7: A request with nonzero `rd_priv_i` and bit 8 of `rd_ctrl_i` clear raises `rd_fault_o` with `rd_err_code_o` = 0. Privilege level 0, or bit 8 set, allows the read. No other control bit affects the outcome.
- R8: Any `rd_sel_i` value other than 0 or 1 raises `rd_fault_o`. All 32 bits are compared, so a value with only a high bit set faults. `rd_narrow_i` (a 16-bit code mode tag) has no effect.
- R9: A fault cycle drives `rd_valid_o`, `rd_hi_o` and `rd_lo_o` to zero. The privilege check is evaluated before the selector check.
- R10: A read, whether granted or faulted, leaves both counters unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| evt_src_i | input | 4 | Event strobes available to the counters |
| cnt_en_i | input | 2 | Per-counter count enable |
| cnt_src_sel_i | input | 4 | Per-counter source index, 2 bits per counter |
| rd_req_i | input | 1 | Read request strobe |
| rd_priv_i | input | 2 | Privilege level of the requester |
| rd_sel_i | input | 32 | Counter selector |
| rd_ctrl_i | input | 32 | Control-register word; bit 8 enables user reads |
| rd_narrow_i | input | 1 | Request comes from 16-bit code; ignored |
| rd_valid_o | output | 1 | Read granted, data valid this cycle |
| rd_fault_o | output | 1 | General-protection fault this cycle |
| rd_err_code_o | output | 16 | Fault error code, always zero |
| rd_hi_o | output | 32 | Upper half of the result |
| rd_lo_o | output | 32 | Lower half of the result |

## Verification
The bound checker verifies the response protocol on every cycle. Each request produces exactly one valid or fault pulse one cycle later, and no pulse appears without a request. Fault cycles carry zero data, every result bit above the counter width is zero, the privilege and selector fault conditions always produce a fault, and a disabled counter holds its value. Other properties depend on stimulus and can only be shown by the bench's directed scenarios: the exact count reached under different source selections and event patterns, the value captured when a read coincides with an advance, wrap-around on a narrow counter instance, the reads that each privilege combination allows, and the claim that reads do not disturb the counts.

// File: rtl/evtcnt_pkg.sv
package evtcnt_pkg;

    localparam int HALF_W     = 32;
    localparam int ERR_CODE_W = 16;

    typedef enum logic [1:0] {
        ACC_GRANT      = 2'd0,
        ACC_PRIV_FAULT = 2'd1,
        ACC_SEL_FAULT  = 2'd2
    } acc_verdict_e;

endpackage

// File: rtl/evtcnt_src_mux.sv
module evtcnt_src_mux #(
    parameter int NUM_SRC = 4,
    parameter int SRC_SEL_W = 2
) (
    input  logic [NUM_SRC-1:0]   src_i,
    input  logic [SRC_SEL_W-1:0] sel_i,
    input  logic                 en_i,
    output logic                 inc_o
);

    logic picked;

    always_comb begin
        picked = 1'b0;
        for (int k = 0; k < NUM_SRC; k++) begin
            if (sel_i == SRC_SEL_W'(k)) begin
                picked = src_i[k];
            end
        end
        inc_o = en_i & picked;
    end

endmodule

// File: rtl/evtcnt_counter.sv
module evtcnt_counter #(
    parameter int CNT_W = 40
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             inc_i,
    output logic [CNT_W-1:0] cnt_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (inc_i) begin
            state_d.cnt = state_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign cnt_o = state_q.cnt;

endmodule

// File: rtl/evtcnt_access_check.sv
module evtcnt_access_check
    import evtcnt_pkg::*;
#(
    parameter int PRIV_W  = 2,
    parameter int CTRL_W  = 32,
    parameter int UEN_BIT = 8,
    parameter int SEL_W   = 32,
    parameter int NUM_CNT = 2,
    localparam int IDX_W  = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1
) (
    input  logic [PRIV_W-1:0] priv_i,
    input  logic [CTRL_W-1:0] ctrl_i,
    input  logic [SEL_W-1:0]  sel_i,
    input  logic              narrow_i,
    output acc_verdict_e      verdict_o,
    output logic [IDX_W-1:0]  idx_o
);

    logic priv_ok;
    logic sel_ok;
    logic unused_req_bits;

    // Only the user-access bit matters; the mode tag never narrows the compare.
    assign unused_req_bits = ^{ctrl_i[CTRL_W-1:UEN_BIT+1], ctrl_i[UEN_BIT-1:0], narrow_i};

    always_comb begin
        priv_ok = (priv_i == '0) || ctrl_i[UEN_BIT];
        sel_ok  = (sel_i < SEL_W'(NUM_CNT));
        idx_o   = sel_i[IDX_W-1:0];
        if (!priv_ok) begin
            verdict_o = ACC_PRIV_FAULT;
        end else if (!sel_ok) begin
            verdict_o = ACC_SEL_FAULT;
        end else begin
            verdict_o = ACC_GRANT;
        end
    end

endmodule

// File: rtl/evt_counter_reader.sv
module evt_counter_reader
    import evtcnt_pkg::*;
#(
    parameter int NUM_CNT   = 2,
    parameter int CNT_W     = 40,
    parameter int NUM_SRC   = 4,
    parameter int SRC_SEL_W = 2,
    parameter int PRIV_W    = 2,
    parameter int SEL_W     = 32,
    parameter int CTRL_W    = 32,
    parameter int UEN_BIT   = 8,
    localparam int RES_W    = 2 * HALF_W,
    localparam int IDX_W    = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1
) (
    input  logic                           clk_i,
    input  logic                           rst_i,
    input  logic [NUM_SRC-1:0]             evt_src_i,
    input  logic [NUM_CNT-1:0]             cnt_en_i,
    input  logic [NUM_CNT*SRC_SEL_W-1:0]   cnt_src_sel_i,
    input  logic                           rd_req_i,
    input  logic [PRIV_W-1:0]              rd_priv_i,
    input  logic [SEL_W-1:0]               rd_sel_i,
    input  logic [CTRL_W-1:0]              rd_ctrl_i,
    input  logic                           rd_narrow_i,
    output logic                           rd_valid_o,
    output logic                           rd_fault_o,
    output logic [ERR_CODE_W-1:0]          rd_err_code_o,
    output logic [HALF_W-1:0]              rd_hi_o,
    output logic [HALF_W-1:0]              rd_lo_o
);

    typedef struct packed {
        logic                  valid;
        logic                  fault;
        logic [ERR_CODE_W-1:0] err;
        logic [RES_W-1:0]      data;
    } rsp_state_t;

    logic [NUM_CNT*CNT_W-1:0] cnt_flat;
    logic [NUM_CNT-1:0]       cnt_inc;
    acc_verdict_e             verdict;
    logic [IDX_W-1:0]         rd_idx;
    logic [CNT_W-1:0]         picked_cnt;
    rsp_state_t               rsp_d, rsp_q;

    for (genvar n = 0; n < NUM_CNT; n++) begin : g_cnt
        evtcnt_src_mux #(
            .NUM_SRC   (NUM_SRC),
            .SRC_SEL_W (SRC_SEL_W)
        ) u_mux (
            .src_i (evt_src_i),
            .sel_i (cnt_src_sel_i[n*SRC_SEL_W +: SRC_SEL_W]),
            .en_i  (cnt_en_i[n]),
            .inc_o (cnt_inc[n])
        );

        evtcnt_counter #(
            .CNT_W (CNT_W)
        ) u_cnt (
            .clk_i (clk_i),
            .rst_i (rst_i),
            .inc_i (cnt_inc[n]),
            .cnt_o (cnt_flat[n*CNT_W +: CNT_W])
        );
    end

    evtcnt_access_check #(
        .PRIV_W  (PRIV_W),
        .CTRL_W  (CTRL_W),
        .UEN_BIT (UEN_BIT),
        .SEL_W   (SEL_W),
        .NUM_CNT (NUM_CNT)
    ) u_acc (
        .priv_i    (rd_priv_i),
        .ctrl_i    (rd_ctrl_i),
        .sel_i     (rd_sel_i),
        .narrow_i  (rd_narrow_i),
        .verdict_o (verdict),
        .idx_o     (rd_idx)
    );

    always_comb begin
        picked_cnt = '0;
        for (int n = 0; n < NUM_CNT; n++) begin
            if (rd_idx == IDX_W'(n)) begin
                picked_cnt = cnt_flat[n*CNT_W +: CNT_W];
            end
        end
    end

    always_comb begin
        rsp_d = '0;
        if (rd_req_i) begin
            if (verdict == ACC_GRANT) begin
                rsp_d.valid = 1'b1;
                rsp_d.data  = RES_W'(picked_cnt);
            end else begin
                rsp_d.fault = 1'b1;
                rsp_d.err   = '0;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rd_valid_o    = rsp_q.valid;
    assign rd_fault_o    = rsp_q.fault;
    assign rd_err_code_o = rsp_q.err;
    assign rd_hi_o       = rsp_q.data[RES_W-1:HALF_W];
    assign rd_lo_o       = rsp_q.data[HALF_W-1:0];

endmodule

// File: rtl/evtcnt_read_checker.sv
module evtcnt_read_checker #(
    parameter int NUM_CNT = 2,
    parameter int CNT_W   = 40,
    parameter int PRIV_W  = 2,
    parameter int SEL_W   = 32,
    parameter int CTRL_W  = 32,
    parameter int UEN_BIT = 8
) (
    input logic                     clk_i,
    input logic                     rst_i,
    input logic                     rd_req_i,
    input logic [PRIV_W-1:0]        rd_priv_i,
    input logic [SEL_W-1:0]         rd_sel_i,
    input logic [CTRL_W-1:0]        rd_ctrl_i,
    input logic [NUM_CNT-1:0]       cnt_en_i,
    input logic                     rd_valid_o,
    input logic                     rd_fault_o,
    input logic [15:0]              rd_err_code_o,
    input logic [31:0]              rd_hi_o,
    input logic [31:0]              rd_lo_o,
    input logic [NUM_CNT*CNT_W-1:0] cnt_flat
);

    // R5: no response pulse without a request one cycle earlier
    a_r5_rsp_needs_req: assert property (@(posedge clk_i) disable iff (rst_i)
        (rd_valid_o || rd_fault_o) |-> $past(rd_req_i));

    // R5: every request gets exactly one of the two outcomes next cycle
    a_r5_req_gets_rsp: assert property (@(posedge clk_i) disable iff (rst_i)
        rd_req_i |=> (rd_valid_o ^ rd_fault_o));

    // R9: fault cycles carry no data and no valid
    a_r9_fault_quiet: assert property (@(posedge clk_i) disable iff (rst_i)
        rd_fault_o |-> (!rd_valid_o && rd_hi_o == '0 && rd_lo_o == '0 && rd_err_code_o == '0));

    // R7: unprivileged request without the user-access bit faults
    a_r7_priv_fault: assert property (@(posedge clk_i) disable iff (rst_i)
        (rd_req_i && rd_priv_i != '0 && !rd_ctrl_i[UEN_BIT]) |=> rd_fault_o);

    // R8: any selector other than 0 or 1 faults
    a_r8_sel_fault: assert property (@(posedge clk_i) disable iff (rst_i)
        (rd_req_i && rd_sel_i > SEL_W'(1)) |=> rd_fault_o);

    // R6: no result bit above the counter width is ever set
    a_r6_zero_ext: assert property (@(posedge clk_i) disable iff (rst_i)
        rd_valid_o |-> (({rd_hi_o, rd_lo_o} >> CNT_W) == 64'd0));

    for (genvar n = 0; n < NUM_CNT; n++) begin : g_hold
        // R1: a disabled counter keeps its value
        a_r1_hold_off: assert property (@(posedge clk_i) disable iff (rst_i)
            !cnt_en_i[n] |=> (cnt_flat[n*CNT_W +: CNT_W] == $past(cnt_flat[n*CNT_W +: CNT_W])));
    end

endmodule

bind evt_counter_reader evtcnt_read_checker #(
    .NUM_CNT (NUM_CNT),
    .CNT_W   (CNT_W),
    .PRIV_W  (PRIV_W),
    .SEL_W   (SEL_W),
    .CTRL_W  (CTRL_W),
    .UEN_BIT (UEN_BIT)
) u_read_chk (
    .clk_i         (clk_i),
    .rst_i         (rst_i),
    .rd_req_i      (rd_req_i),
    .rd_priv_i     (rd_priv_i),
    .rd_sel_i      (rd_sel_i),
    .rd_ctrl_i     (rd_ctrl_i),
    .cnt_en_i      (cnt_en_i),
    .rd_valid_o    (rd_valid_o),
    .rd_fault_o    (rd_fault_o),
    .rd_err_code_o (rd_err_code_o),
    .rd_hi_o       (rd_hi_o),
    .rd_lo_o       (rd_lo_o),
    .cnt_flat      (cnt_flat)
);

// File: tb/evt_counter_reader_tb_top.sv
`timescale 1ns/1ps
module evt_counter_reader_tb_top;

    localparam int NARROW_W = 8;
    localparam logic [31:0] UEN = 32'h0000_0100;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  evt_src = '0;
    logic [1:0]  cnt_en = '0;
    logic [3:0]  src_sel = '0;
    logic        req = 1'b0;
    logic [1:0]  priv = '0;
    logic [31:0] sel = '0;
    logic [31:0] ctrl = '0;
    logic        narrow = 1'b0;

    logic        valid, fault, w_valid, w_fault;
    logic [15:0] err, w_err;
    logic [31:0] hi, lo, w_hi, w_lo;

    int n_checks = 0;
    int n_fail = 0;

    logic [39:0] mdl [2];

    always #4 clk = ~clk;

    evt_counter_reader dut_i (
        .clk_i (clk), .rst_i (rst), .evt_src_i (evt_src), .cnt_en_i (cnt_en),
        .cnt_src_sel_i (src_sel), .rd_req_i (req), .rd_priv_i (priv),
        .rd_sel_i (sel), .rd_ctrl_i (ctrl), .rd_narrow_i (narrow),
        .rd_valid_o (valid), .rd_fault_o (fault), .rd_err_code_o (err),
        .rd_hi_o (hi), .rd_lo_o (lo)
    );

    evt_counter_reader #(.CNT_W (NARROW_W)) dut_w (
        .clk_i (clk), .rst_i (rst), .evt_src_i (evt_src), .cnt_en_i (cnt_en),
        .cnt_src_sel_i (src_sel), .rd_req_i (req), .rd_priv_i (priv),
        .rd_sel_i (sel), .rd_ctrl_i (ctrl), .rd_narrow_i (narrow),
        .rd_valid_o (w_valid), .rd_fault_o (w_fault), .rd_err_code_o (w_err),
        .rd_hi_o (w_hi), .rd_lo_o (w_lo)
    );

    // Reference counts built from R1/R2/R3/R4
    always @(posedge clk) begin
        for (int n = 0; n < 2; n++) begin
            if (rst) mdl[n] <= '0;
            else if (cnt_en[n] && evt_src[src_sel[2*n +: 2]]) mdl[n] <= mdl[n] + 40'd1;
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Issue one read; returns the value the models held at the capture edge.
    task automatic do_read(input logic [1:0] p, input logic [31:0] s, input logic [31:0] c,
                           input logic nw, output logic [39:0] exp0, output logic [39:0] exp1);
        @(negedge clk);
        priv = p; sel = s; ctrl = c; narrow = nw; req = 1'b1;
        exp0 = mdl[0]; exp1 = mdl[1];
        @(posedge clk);
        @(negedge clk);
        req = 1'b0;
    endtask

    task automatic idle(input int cyc);
        repeat (cyc) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [39:0] e0, e1;
        chk("R4 valid after reset", {63'd0, valid}, 64'd0);
        chk("R4 fault after reset", {63'd0, fault}, 64'd0);
        chk("R4 data after reset", {hi, lo}, 64'd0);
        do_read(2'd0, 32'd1, 32'd0, 1'b0, e0, e1);
        chk("R4 counter1 zero", {hi, lo}, 64'd0);
    endtask

    task automatic t_count_and_wrap;
        logic [39:0] e0, e1;
        @(negedge clk);
        src_sel = 4'b1000; cnt_en = 2'b01; evt_src = 4'b0001;
        idle(300);
        @(negedge clk); evt_src = '0;
        do_read(2'd0, 32'd0, 32'd0, 1'b0, e0, e1);
        chk("R1 counter0 count", {hi, lo}, {24'd0, e0});
        chk("R1 counter0 is 301", {hi, lo}, 64'd301);
        chk("R3 narrow wrap", {w_hi, w_lo}, 64'(301 % 256));
        chk("R6 narrow upper zero", {32'd0, w_hi}, 64'd0);
        do_read(2'd0, 32'd1, 32'd0, 1'b0, e0, e1);
        chk("R1 counter1 idle", {hi, lo}, 64'd0);
    endtask

    task automatic t_src_select;
        logic [39:0] e0, e1;
        @(negedge clk);
        cnt_en = 2'b11; src_sel = 4'b1101;  // counter0 <- src1, counter1 <- src3
        for (int i = 0; i < 120; i++) begin
            @(negedge clk);
            evt_src = 4'((i * 7 + 3) ^ (i >> 2));
        end
        @(negedge clk); evt_src = '0;
        do_read(2'd0, 32'd0, 32'd0, 1'b0, e0, e1);
        chk("R2 counter0 via src1", {hi, lo}, {24'd0, e0});
        do_read(2'd0, 32'd1, 32'd0, 1'b0, e0, e1);
        chk("R2 counter1 via src3", {hi, lo}, {24'd0, e1});
        chk("R6 counter1 lo only", {32'd0, hi}, 64'd0);
    endtask

    task automatic t_timing;
        logic [39:0] e0, e1;
        @(negedge clk);
        src_sel = 4'b0000; cnt_en = 2'b01; evt_src = 4'b0001;
        do_read(2'd0, 32'd0, 32'd0, 1'b0, e0, e1);
        chk("R5 pre-increment value", {hi, lo}, {24'd0, e0});
        chk("R5 valid pulse", {63'd0, valid}, 64'd1);
        @(negedge clk);
        chk("R5 pulse single cycle", {62'd0, valid, fault}, 64'd0);
        cnt_en = 2'b00; evt_src = '0;
    endtask

    task automatic t_priv;
        logic [39:0] e0, e1;
        do_read(2'd3, 32'd0, 32'd0, 1'b0, e0, e1);
        chk("R7 user no enable faults", {62'd0, valid, fault}, 64'd1);
        chk("R7 err code zero", {48'd0, err}, 64'd0);
        do_read(2'd1, 32'd0, ~UEN, 1'b0, e0, e1);
        chk("R7 other ctrl bits ignored", {62'd0, valid, fault}, 64'd1);
        do_read(2'd3, 32'd0, UEN, 1'b0, e0, e1);
        chk("R7 user with enable granted", {62'd0, valid, fault}, 64'd2);
        chk("R7 user read data", {hi, lo}, {24'd0, e0});
        do_read(2'd0, 32'd0, 32'd0, 1'b0, e0, e1);
        chk("R7 level zero granted", {62'd0, valid, fault}, 64'd2);
    endtask

    task automatic t_sel;
        logic [39:0] e0, e1;
        do_read(2'd0, 32'd2, 32'd0, 1'b0, e0, e1);
        chk("R8 selector 2 faults", {62'd0, valid, fault}, 64'd1);
        do_read(2'd0, 32'h8000_0000, 32'd0, 1'b0, e0, e1);
        chk("R8 top bit faults", {62'd0, valid, fault}, 64'd1);
        do_read(2'd0, 32'h0001_0000, 32'd0, 1'b1, e0, e1);
        chk("R8 high bit in 16-bit mode faults", {62'd0, valid, fault}, 64'd1);
        do_read(2'd0, 32'd1, 32'd0, 1'b1, e0, e1);
        chk("R8 16-bit mode selector 1 granted", {hi, lo}, {24'd0, e1});
    endtask

    task automatic t_fault_data;
        logic [39:0] e0, e1;
        do_read(2'd0, 32'd0, 32'd0, 1'b0, e0, e1);
        chk("R9 prior read nonzero", {63'd0, ({hi, lo} != 64'd0)}, 64'd1);
        do_read(2'd2, 32'h0000_0101, 32'd0, 1'b0, e0, e1);
        chk("R9 fault data zero", {hi, lo}, 64'd0);
        chk("R9 fault no valid", {62'd0, valid, fault}, 64'd1);
    endtask

    task automatic t_nondestructive;
        logic [39:0] e0, e1;
        logic [63:0] first;
        do_read(2'd0, 32'd1, 32'd0, 1'b0, e0, e1);
        first = {hi, lo};
        do_read(2'd3, 32'd5, 32'd0, 1'b0, e0, e1);
        do_read(2'd0, 32'd1, 32'd0, 1'b0, e0, e1);
        chk("R10 reads leave counter1", {hi, lo}, first);
        chk("R10 matches model", {hi, lo}, {24'd0, e1});
    endtask

    task automatic t_mid_reset;
        logic [39:0] e0, e1;
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        do_read(2'd0, 32'd0, 32'd0, 1'b0, e0, e1);
        chk("R4 counter0 cleared", {hi, lo}, 64'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_count_and_wrap();
        t_src_select();
        t_timing();
        t_priv();
        t_sel();
        t_fault_data();
        t_nondestructive();
        t_mid_reset();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule